// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in and returns a 16-bit sum and a carry-out. The operands are split into four 4-bit slices. Each slice forms per-bit generate (AND of the operand bits) and propagate (inclusive OR of the operand bits). A 4-bit lookahead unit turns these into the slice's internal carries and its group generate and propagate. A second lookahead unit of the same form takes the four group pairs and the adder carry-in, and computes the carry into every slice at once. No carry ripples from one slice to the next.

Each sum bit is the XOR of the two operand bits and the carry into that bit. The group generate and propagate of the whole 16 bits are also brought out, so that a wider adder can use this block as one group of its own lookahead tree. An output register stage is built when `RegOut` is 1, which is the default. It puts sum, carry-out and group signals behind one flop stage, so the adder sits between registers for timing work. With `RegOut` set to 0 the outputs are combinational.

Top module: `cla16_adder`

## Requirements
- R1: With `RegOut`=1, `sumOut` equals (`aIn` + `bIn` + `cIn`) mod 65536, taken from the inputs present at the previous rising clock edge.
- R2: `coutOut` is bit 16 of the 17-bit result `aIn` + `bIn` + `cIn`, with the same one-cycle latency as the sum.
- R3: While `rstN` is low, `sumOut`, `coutOut`, `grpPOut` and `grpGOut` are all 0, whatever the inputs are.
- R4: The carry leaving each 4-bit slice, worked out inside that slice, equals the carry the second-level unit computes for the next slice. The top carry equals the adder carry-out.
- R5: `grpPOut` is 1 exactly when every bit position i has `aIn[i]` OR `bIn[i]` equal to 1.
- R6: `grpGOut` is 1 exactly when `aIn` + `bIn` overflows 16 bits with no carry-in.
- R7: `coutOut` equals `grpGOut` OR (`grpPOut` AND the registered `cIn`).
- R8: A carry that enters at bit 0 travels through all four slice boundaries. For example, 0xFFFF + 0x0000 + 1 gives sum 0x0000 and carry-out 1, and 0x0F0F + 0xF0F0 + 1 behaves the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rstN | input | 1 | Asynchronous active-low reset of the output stage |
| aIn | input | 16 | First operand |
| bIn | input | 16 | Second operand |
| cIn | input | 1 | Carry into bit 0 |
| sumOut | output | 16 | Sum bits |
| coutOut | output | 1 | Carry out of bit 15 |
| grpPOut | output | 1 | Propagate of the full 16-bit group |
| grpGOut | output | 1 | Generate of the full 16-bit group |

## Verification
Every output comes from one register stage. The result for operands applied before a rising edge is therefore due just after that edge and holds until the next one. The bench changes operands on the falling edge, waits for one rising edge, and samples all four outputs on the following falling edge. The expected values come from a behavioural 17-bit addition and from OR and AND reductions of the operands. These are checked against both carry-in values for table vectors, random vectors and carry chains that cross every slice boundary.

// File: rtl/cla_pkg.sv
package cla_pkg;
  parameter int SliceW    = 4;
  parameter int NumSlices = 4;
  localparam int AddW     = SliceW * NumSlices;

  // Registered result bundle carried by the output stage
  typedef struct packed {
    logic [AddW-1:0] sum;
    logic            cout;
    logic            grpP;
    logic            grpG;
  } addRes_t;
endpackage

// File: rtl/cla_lookahead.sv
// Lookahead unit: carries 1..N computed in parallel as flat sums of products.
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] pIn,
  input  logic [N-1:0] gIn,
  input  logic         cIn,
  output logic [N:1]   carry,
  output logic         grpP,
  output logic         grpG
);
  always_comb begin
    logic acc;
    logic prod;
    carry = '0;
    for (int k = 1; k <= N; k++) begin
      acc = 1'b0;
      for (int j = 0; j < k; j++) begin
        prod = gIn[j];
        for (int m = j + 1; m < k; m++) prod = prod & pIn[m];
        acc = acc | prod;
      end
      prod = cIn;
      for (int m = 0; m < k; m++) prod = prod & pIn[m];
      carry[k] = acc | prod;
    end
  end

  // Group terms: generate excludes the carry-in term
  always_comb begin
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      prod = gIn[j];
      for (int m = j + 1; m < N; m++) prod = prod & pIn[m];
      acc = acc | prod;
    end
    grpG = acc;
    grpP = &pIn;
  end
endmodule

// File: rtl/cla_slice.sv
// One 4-bit slice: bit p/g, local lookahead, XOR sum.
module cla_slice
  import cla_pkg::*;
(
  input  logic [SliceW-1:0] aIn,
  input  logic [SliceW-1:0] bIn,
  input  logic              cIn,
  output logic [SliceW-1:0] sum,
  output logic              cout,
  output logic              grpP,
  output logic              grpG
);
  logic [SliceW-1:0] bitP;
  logic [SliceW-1:0] bitG;
  logic [SliceW:1]   localCarry;
  logic [SliceW-1:0] bitCarry;

  for (genvar i = 0; i < SliceW; i++) begin : g_bit
    assign bitG[i] = aIn[i] & bIn[i];
    assign bitP[i] = aIn[i] | bIn[i];
  end

  cla_lookahead #(.N(SliceW)) u_la (
    .pIn   (bitP),
    .gIn   (bitG),
    .cIn   (cIn),
    .carry (localCarry),
    .grpP  (grpP),
    .grpG  (grpG)
  );

  assign bitCarry = {localCarry[SliceW-1:1], cIn};
  assign sum      = aIn ^ bIn ^ bitCarry;
  assign cout     = localCarry[SliceW];
endmodule

// File: rtl/cla_outreg.sv
// Optional output stage; RegOut picks flops or a plain wire.
module cla_outreg
  import cla_pkg::*;
#(
  parameter bit RegOut = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  addRes_t dIn,
  output addRes_t qOut
);
  if (RegOut) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) qOut <= '0;
      else       qOut <= dIn;
    end
  end else begin : g_wire
    assign qOut = dIn;
  end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
  import cla_pkg::*;
#(
  parameter bit RegOut = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AddW-1:0] aIn,
  input  logic [AddW-1:0] bIn,
  input  logic            cIn,
  output logic [AddW-1:0] sumOut,
  output logic            coutOut,
  output logic            grpPOut,
  output logic            grpGOut
);
  logic [NumSlices-1:0] sliceP;
  logic [NumSlices-1:0] sliceG;
  logic [NumSlices-1:0] sliceCout;
  logic [NumSlices-1:0] sliceCin;
  logic [NumSlices:1]   topCarry;
  logic [AddW-1:0]      sumNext;
  logic                 topP;
  logic                 topG;
  addRes_t              resNext;
  addRes_t              resQ;

  assign sliceCin = {topCarry[NumSlices-1:1], cIn};

  for (genvar s = 0; s < NumSlices; s++) begin : g_slice
    cla_slice u_slice (
      .aIn  (aIn[s*SliceW +: SliceW]),
      .bIn  (bIn[s*SliceW +: SliceW]),
      .cIn  (sliceCin[s]),
      .sum  (sumNext[s*SliceW +: SliceW]),
      .cout (sliceCout[s]),
      .grpP (sliceP[s]),
      .grpG (sliceG[s])
    );

    // R4: slice-local carry-out agrees with the second-level carry
    p_slice_carry_r4 : assert property (@(posedge clk) disable iff (!rstN)
      sliceCout[s] == topCarry[s+1]);
  end

  cla_lookahead #(.N(NumSlices)) u_top_la (
    .pIn   (sliceP),
    .gIn   (sliceG),
    .cIn   (cIn),
    .carry (topCarry),
    .grpP  (topP),
    .grpG  (topG)
  );

  assign resNext.sum  = sumNext;
  assign resNext.cout = topCarry[NumSlices];
  assign resNext.grpP = topP;
  assign resNext.grpG = topG;

  cla_outreg #(.RegOut(RegOut)) u_out (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (resNext),
    .qOut (resQ)
  );

  assign sumOut  = resQ.sum;
  assign coutOut = resQ.cout;
  assign grpPOut = resQ.grpP;
  assign grpGOut = resQ.grpG;

  // R6: group generate equals overflow of a+b with no carry-in
  p_group_gen_r6 : assert property (@(posedge clk) disable iff (!rstN)
    topG == ((({1'b0, aIn} + {1'b0, bIn}) >> AddW) != '0));

  if (RegOut) begin : g_chk
    // R1: registered sum matches behavioural addition one cycle later
    p_sum_r1 : assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> sumOut == $past(aIn + bIn + AddW'(cIn)));
    // R2: registered carry-out is bit 16 of the behavioural result
    p_cout_r2 : assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> coutOut == $past(((({1'b0, aIn} + {1'b0, bIn}) + (AddW+1)'(cIn)) >> AddW) != '0));
  end
endmodule

// File: tb/cla16_adder_tb.sv
module cla16_adder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] aIn = '0;
  logic [15:0] bIn = '0;
  logic        cIn = 1'b0;
  logic [15:0] sumOut;
  logic        coutOut;
  logic        grpPOut;
  logic        grpGOut;

  int errCnt = 0;
  int chkCnt = 0;

  always #2 clk = ~clk;

  cla16_adder u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .aIn     (aIn),
    .bIn     (bIn),
    .cIn     (cIn),
    .sumOut  (sumOut),
    .coutOut (coutOut),
    .grpPOut (grpPOut),
    .grpGOut (grpGOut)
  );

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
  } vec_t;

  localparam int NumVec = 10;
  localparam vec_t Vecs [NumVec] = '{
    '{16'h0000, 16'h0000},
    '{16'hFFFF, 16'h0001},
    '{16'hFFFF, 16'h0000},
    '{16'hAAAA, 16'h5555},
    '{16'h5555, 16'h5555},
    '{16'hAAAA, 16'hAAAA},
    '{16'h0F0F, 16'hF0F0},
    '{16'h000F, 16'h0001},
    '{16'h8000, 16'h8000},
    '{16'h1234, 16'hEDCB}
  };

  task automatic check(string req, logic [16:0] act, logic [16:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at falling edge, register at rising edge, sample at next falling edge
  task automatic applyCheck(logic [15:0] a, logic [15:0] b, logic c);
    logic [16:0] full;
    logic        expP;
    logic        expG;
    aIn = a; bIn = b; cIn = c;
    @(posedge clk);
    @(negedge clk);
    full = {1'b0, a} + {1'b0, b} + 17'(c);
    expP = &(a | b);
    expG = (({1'b0, a} + {1'b0, b}) >> 16) != 17'd0;
    check("R1 sum",  {1'b0, sumOut}, {1'b0, full[15:0]});
    check("R2 cout", {16'd0, coutOut}, {16'd0, full[16]});
    check("R5 grpP", {16'd0, grpPOut}, {16'd0, expP});
    check("R6 grpG", {16'd0, grpGOut}, {16'd0, expG});
    check("R7 cout from group", {16'd0, coutOut}, {16'd0, grpGOut | (grpPOut & c)});
  endtask

  initial begin
    #(4 * 200000);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    // R3: outputs held at zero during reset even with active inputs
    aIn = 16'hFFFF; bIn = 16'hFFFF; cIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 sum in reset",  {1'b0, sumOut}, 17'd0);
    check("R3 flags in reset", {14'd0, coutOut, grpPOut, grpGOut}, 17'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NumVec; i++) begin
      for (int c = 0; c < 2; c++) applyCheck(Vecs[i].a, Vecs[i].b, c[0]);
    end

    // R8 / R4: carry chained through every slice boundary
    applyCheck(16'hFFFF, 16'h0000, 1'b1);
    check("R8 full chain sum",  {1'b0, sumOut}, 17'd0);
    check("R8 full chain cout", {16'd0, coutOut}, 17'd1);
    applyCheck(16'h0F0F, 16'hF0F0, 1'b1);
    check("R8 mixed chain", {coutOut, sumOut}, 17'h10000);
    for (int s = 0; s < 4; s++) begin
      // R4: carry generated in slice s must reach slice s+1
      logic [15:0] a;
      a = 16'hFFFF >> (4 * s);
      applyCheck(a, 16'h0001, 1'b0);
    end

    for (int i = 0; i < 300; i++) begin
      applyCheck(16'($urandom), 16'($urandom), 1'($urandom));
    end

    // R3: reset asserted again mid-run clears registered outputs
    aIn = 16'hFFFF; bIn = 16'h0001; cIn = 1'b1;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R3 async clear", {coutOut, sumOut}, 17'd0);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule